// File: doc/BRIEF.md
# Tagged-Token Operand Matching Store

This block is the associative waiting area of a dataflow processor. Instructions are loaded with an opcode, a destination tag and two operand tags. They wait until their operands arrive. Each entry compares every returning data token's tag with its two operand slots in the same cycle. Every slot still waiting on that tag takes the token's value, so one token can feed several instructions. The token is not stored anywhere else.

Once both slots of an entry are filled, the entry is ready. The block sends it to the single execution unit as one packet: opcode, destination tag and both operand values. If several entries are ready, the lowest-numbered one goes first. Dispatch frees the entry for a new load. Execution order therefore follows operand arrival, not load order, and there is no program counter. All three ports use valid/ready handshakes.

Top module: `tt_match_store`

## Requirements
- R1: After reset no entry is occupied: `pkt_valid` is 0, `ins_ready` is 1 and `tok_ready` is 1.
- R2: An accepted token is compared with every waiting operand slot at once. Each slot of an occupied entry whose expected tag equals the token tag and is still empty captures the token data. This includes both slots of one entry and slots in different entries.
- R3: A packet is offered only from an occupied entry whose two slots are both filled. The packet carries that entry's opcode and destination tag. `pkt_a` holds the first-slot value and `pkt_b` the second-slot value.
- R4: When several entries are ready, the entry with the lowest index is presented. Loads fill the lowest-index free entry.
- R5: At most one packet is dispatched per cycle, on a cycle where `pkt_valid` and `pkt_ready` are both 1. While `pkt_ready` is 0, `pkt_valid` stays 1 and no entry is released.
- R6: `ins_ready` is 0 exactly when all ENTRIES entries are occupied. A dispatch frees its entry, and `ins_ready` returns to 1 on the next cycle.
- R7: `tok_ready` is always 1. A token whose tag matches no waiting slot is accepted and has no effect on any entry.
- R8: A token accepted in the same cycle as an instruction load is also matched against the operand tags of the instruction being loaded.
- R9: Dispatch order follows operand completion, not load order. An entry loaded later but completed first is dispatched first.
- R10: A token is not retained after its accept cycle. An instruction loaded afterwards that expects the same tag stays waiting for a new token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction load request |
| ins_ready | output | 1 | A free entry exists |
| ins_op | input | OP_W | Opcode of the loaded instruction |
| ins_dest | input | TAG_W | Destination tag of the loaded instruction |
| ins_tag_a | input | TAG_W | Expected tag of the first operand |
| ins_tag_b | input | TAG_W | Expected tag of the second operand |
| tok_valid | input | 1 | Data token present |
| tok_ready | output | 1 | Token accept, always 1 |
| tok_tag | input | TAG_W | Tag of the data token |
| tok_data | input | DATA_W | Value of the data token |
| pkt_valid | output | 1 | Ready instruction packet offered |
| pkt_ready | input | 1 | Execution unit accepts the packet |
| pkt_op | output | OP_W | Packet opcode |
| pkt_dest | output | TAG_W | Packet destination tag |
| pkt_a | output | DATA_W | First operand value |
| pkt_b | output | DATA_W | Second operand value |

## Verification
The bound checker tracks occupancy from the load and dispatch handshakes. On every cycle it confirms that `ins_ready` agrees with that count, that no packet appears while the store is empty, and that the presented entry is the lowest ready one. It also confirms that an offered packet is still offered after a stalled cycle. Tag matching is shown only by the bench's scenarios: broadcast capture into several slots, the same-cycle load and token, dropped unmatched tokens, non-retention, and out-of-order completion. Those scenarios also check the operand values carried in each packet.

// File: rtl/tt_match_pkg.sv
package tt_match_pkg;
  localparam int unsigned TTM_ENTRIES = 8;
  localparam int unsigned TTM_TAG_W   = 6;
  localparam int unsigned TTM_DATA_W  = 16;
  localparam int unsigned TTM_OP_W    = 4;
endpackage

// File: rtl/tt_lowest_pick.sv
module tt_lowest_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
  assign any = seen[N];
endmodule

// File: rtl/tt_entry.sv
module tt_entry #(
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [OP_W-1:0]   ld_op,
  input  logic [TAG_W-1:0]  ld_dest,
  input  logic [TAG_W-1:0]  ld_tag_a,
  input  logic [TAG_W-1:0]  ld_tag_b,
  input  logic              tok_fire,
  input  logic [TAG_W-1:0]  tok_tag,
  input  logic [DATA_W-1:0] tok_data,
  input  logic              release_en,
  output logic              busy,
  output logic              fire_ok,
  output logic [OP_W-1:0]   op,
  output logic [TAG_W-1:0]  dest,
  output logic [DATA_W-1:0] val_a,
  output logic [DATA_W-1:0] val_b
);
  logic              busy_q, busy_d;
  logic              has_a_q, has_a_d, has_b_q, has_b_d;
  logic [OP_W-1:0]   op_q;
  logic [TAG_W-1:0]  dest_q, want_a_q, want_b_q;
  logic [DATA_W-1:0] va_q, vb_q;
  logic              cap_a, cap_b;

  always_comb begin
    if (load_en) begin
      cap_a = tok_fire && (tok_tag == ld_tag_a);
      cap_b = tok_fire && (tok_tag == ld_tag_b);
    end else begin
      cap_a = tok_fire && busy_q && !has_a_q && (tok_tag == want_a_q);
      cap_b = tok_fire && busy_q && !has_b_q && (tok_tag == want_b_q);
    end
    if (release_en) begin
      busy_d  = 1'b0;
      has_a_d = 1'b0;
      has_b_d = 1'b0;
    end else if (load_en) begin
      busy_d  = 1'b1;
      has_a_d = cap_a;
      has_b_d = cap_b;
    end else begin
      busy_d  = busy_q;
      has_a_d = has_a_q | cap_a;
      has_b_d = has_b_q | cap_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      has_a_q <= 1'b0;
      has_b_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      has_a_q <= has_a_d;
      has_b_q <= has_b_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      op_q     <= ld_op;
      dest_q   <= ld_dest;
      want_a_q <= ld_tag_a;
      want_b_q <= ld_tag_b;
    end
    if (cap_a) va_q <= tok_data;
    if (cap_b) vb_q <= tok_data;
  end

  assign busy    = busy_q;
  assign fire_ok = busy_q & has_a_q & has_b_q;
  assign op      = op_q;
  assign dest    = dest_q;
  assign val_a   = va_q;
  assign val_b   = vb_q;
endmodule

// File: rtl/tt_match_store.sv
module tt_match_store
  import tt_match_pkg::*;
#(
  parameter int unsigned ENTRIES = TTM_ENTRIES,
  parameter int unsigned TAG_W   = TTM_TAG_W,
  parameter int unsigned DATA_W  = TTM_DATA_W,
  parameter int unsigned OP_W    = TTM_OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [OP_W-1:0]   ins_op,
  input  logic [TAG_W-1:0]  ins_dest,
  input  logic [TAG_W-1:0]  ins_tag_a,
  input  logic [TAG_W-1:0]  ins_tag_b,
  input  logic              tok_valid,
  output logic              tok_ready,
  input  logic [TAG_W-1:0]  tok_tag,
  input  logic [DATA_W-1:0] tok_data,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [OP_W-1:0]   pkt_op,
  output logic [TAG_W-1:0]  pkt_dest,
  output logic [DATA_W-1:0] pkt_a,
  output logic [DATA_W-1:0] pkt_b
);
  logic [ENTRIES-1:0] busy, fire_ok, free_sel, disp_sel, load_en, rel_en;
  logic               free_any, ins_fire, pkt_fire, tok_fire;
  logic [OP_W-1:0]    ent_op   [ENTRIES];
  logic [TAG_W-1:0]   ent_dest [ENTRIES];
  logic [DATA_W-1:0]  ent_a    [ENTRIES];
  logic [DATA_W-1:0]  ent_b    [ENTRIES];

  assign tok_ready = 1'b1;
  assign tok_fire  = tok_valid;

  tt_lowest_pick #(.N(ENTRIES)) u_free_pick (
    .req(~busy), .grant(free_sel), .any(free_any)
  );
  tt_lowest_pick #(.N(ENTRIES)) u_disp_pick (
    .req(fire_ok), .grant(disp_sel), .any(pkt_valid)
  );

  assign ins_ready = free_any;
  assign ins_fire  = ins_valid & free_any;
  assign pkt_fire  = pkt_valid & pkt_ready;
  assign load_en   = free_sel & {ENTRIES{ins_fire}};
  assign rel_en    = disp_sel & {ENTRIES{pkt_fire}};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    tt_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .load_en(load_en[i]),
      .ld_op(ins_op), .ld_dest(ins_dest),
      .ld_tag_a(ins_tag_a), .ld_tag_b(ins_tag_b),
      .tok_fire(tok_fire), .tok_tag(tok_tag), .tok_data(tok_data),
      .release_en(rel_en[i]),
      .busy(busy[i]), .fire_ok(fire_ok[i]),
      .op(ent_op[i]), .dest(ent_dest[i]),
      .val_a(ent_a[i]), .val_b(ent_b[i])
    );
  end

  always_comb begin
    pkt_op   = '0;
    pkt_dest = '0;
    pkt_a    = '0;
    pkt_b    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (disp_sel[i]) begin
        pkt_op   = pkt_op   | ent_op[i];
        pkt_dest = pkt_dest | ent_dest[i];
        pkt_a    = pkt_a    | ent_a[i];
        pkt_b    = pkt_b    | ent_b[i];
      end
    end
  end
endmodule

// File: rtl/tt_match_store_chk.sv
module tt_match_store_chk #(
  parameter int unsigned ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_valid,
  input logic               ins_ready,
  input logic               pkt_valid,
  input logic               pkt_ready,
  input logic [ENTRIES-1:0] ent_ready,
  input logic [ENTRIES-1:0] ent_sel
);
  localparam int unsigned CW = $clog2(ENTRIES + 1);
  logic [CW-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + CW'(ins_valid && ins_ready) - CW'(pkt_valid && pkt_ready);
  end

  a_r6_full_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(ENTRIES)) |-> !ins_ready);
  a_r6_room_allows_load: assert property (@(posedge clk) disable iff (!rst_n)
    (occ < CW'(ENTRIES)) |-> ins_ready);
  a_r1_empty_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !pkt_valid);
  a_r4_lowest_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> ($countones(ent_sel) == 1 && (ent_sel & ent_ready) == ent_sel
                   && ((ent_sel - 1'b1) & ent_ready) == '0));
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> pkt_valid);
endmodule

bind tt_match_store tt_match_store_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ins_valid(ins_valid), .ins_ready(ins_ready),
  .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .ent_ready(fire_ok), .ent_sel(disp_sel)
);

// File: tb/tt_match_store_test.sv
module tt_match_store_test;
  localparam int TAG_W = 6, DATA_W = 16, OP_W = 4, ENTRIES = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, tok_valid = 1'b0, pkt_ready = 1'b0;
  logic [OP_W-1:0] ins_op = '0;
  logic [TAG_W-1:0] ins_dest = '0, ins_tag_a = '0, ins_tag_b = '0, tok_tag = '0;
  logic [DATA_W-1:0] tok_data = '0;
  logic ins_ready, tok_ready, pkt_valid;
  logic [OP_W-1:0] pkt_op;
  logic [TAG_W-1:0] pkt_dest;
  logic [DATA_W-1:0] pkt_a, pkt_b;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  tt_match_store uut (.*);

  function automatic logic [DATA_W-1:0] tv(input int tag);
    return DATA_W'(tag * 7 + 100);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    ins_valid = 1'b0; tok_valid = 1'b0; pkt_ready = 1'b0;
  endtask

  task automatic put_ins(input int op, input int dest, input int ta, input int tb, input bit tok,
                         input int ttag, input string req);
    chk(ins_ready == 1'b1, req, "ins_ready before load", 32'(ins_ready), 1);
    ins_valid = 1'b1; ins_op = OP_W'(op); ins_dest = TAG_W'(dest);
    ins_tag_a = TAG_W'(ta); ins_tag_b = TAG_W'(tb);
    if (tok) begin tok_valid = 1'b1; tok_tag = TAG_W'(ttag); tok_data = tv(ttag); end
    step();
  endtask

  task automatic put_tok(input int tag);
    tok_valid = 1'b1; tok_tag = TAG_W'(tag); tok_data = tv(tag);
    step();
  endtask

  task automatic take(input int op, input int dest, input int ta, input int tb, input string req);
    chk(pkt_valid == 1'b1, req, "pkt_valid", 32'(pkt_valid), 1);
    chk(pkt_op == OP_W'(op), req, "pkt_op", 32'(pkt_op), 32'(op));
    chk(pkt_dest == TAG_W'(dest), req, "pkt_dest", 32'(pkt_dest), 32'(dest));
    chk(pkt_a == tv(ta), req, "pkt_a", 32'(pkt_a), 32'(tv(ta)));
    chk(pkt_b == tv(tb), req, "pkt_b", 32'(pkt_b), 32'(tv(tb)));
    pkt_ready = 1'b1;
    step();
  endtask

  task automatic idle(input string req);
    chk(pkt_valid == 1'b0, req, "pkt_valid idle", 32'(pkt_valid), 0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    idle("R1");
    chk(ins_ready == 1'b1, "R1", "ins_ready", 32'(ins_ready), 1);
    chk(tok_ready == 1'b1, "R1", "tok_ready", 32'(tok_ready), 1);

    // R2 / R3: one token feeds two entries; partial entries stay quiet
    put_ins(1, 10, 1, 2, 0, 0, "R2");
    put_ins(2, 11, 1, 3, 0, 0, "R2");
    put_tok(1);
    idle("R3");
    put_tok(2);
    take(1, 10, 1, 2, "R3");
    idle("R3");
    put_tok(3);
    take(2, 11, 1, 3, "R2");
    // R2 both slots of one entry on the same tag
    put_ins(3, 12, 5, 5, 0, 0, "R2");
    put_tok(5);
    take(3, 12, 5, 5, "R2");

    // R9 later-loaded entry completes first
    put_ins(4, 20, 20, 21, 0, 0, "R9");
    put_ins(5, 21, 22, 23, 0, 0, "R9");
    put_tok(23); put_tok(22);
    take(5, 21, 22, 23, "R9");
    put_tok(21); put_tok(20);
    take(4, 20, 20, 21, "R9");

    // R7 unmatched token dropped; R10 not retained
    chk(tok_ready == 1'b1, "R7", "tok_ready", 32'(tok_ready), 1);
    put_tok(60);
    idle("R7");
    chk(ins_ready == 1'b1, "R7", "ins_ready", 32'(ins_ready), 1);
    put_ins(6, 30, 60, 61, 0, 0, "R10");
    put_tok(61);
    idle("R10");
    put_tok(60);
    take(6, 30, 60, 61, "R10");

    // R8 token in the load cycle, matching both the old and the new entry
    put_ins(7, 40, 50, 51, 0, 0, "R8");
    put_tok(50);
    put_ins(8, 41, 51, 52, 1, 51, "R8");
    take(7, 40, 50, 51, "R8");
    idle("R8");
    put_tok(52);
    take(8, 41, 51, 52, "R8");

    // R6 fill every entry
    for (int i = 0; i < ENTRIES; i++) begin
      put_ins(i, 32 + i, 2 * i + 10, 2 * i + 11, 0, 0, "R6");
    end
    chk(ins_ready == 1'b0, "R6", "ins_ready full", 32'(ins_ready), 0);
    put_tok(21); put_tok(20);
    take(5, 37, 20, 21, "R6");
    chk(ins_ready == 1'b1, "R6", "ins_ready after release", 32'(ins_ready), 1);
    put_ins(15, 45, 40, 41, 0, 0, "R6");
    chk(ins_ready == 1'b0, "R6", "ins_ready refilled", 32'(ins_ready), 0);

    // R4 / R5 complete in reverse order, then drain by index
    put_tok(41); put_tok(40);
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (i != 5) begin put_tok(2 * i + 11); put_tok(2 * i + 10); end
    end
    for (int k = 0; k < 3; k++) begin
      chk(pkt_valid == 1'b1, "R5", "stall holds", 32'(pkt_valid), 1);
      chk(pkt_op == 4'd0, "R4", "lowest under stall", 32'(pkt_op), 0);
      step();
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (i == 5) take(15, 45, 40, 41, "R4");
      else take(i, 32 + i, 2 * i + 10, 2 * i + 11, "R4");
    end
    idle("R5");
    chk(ins_ready == 1'b1, "R6", "ins_ready empty", 32'(ins_ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule